// File: doc/BRIEF.md
# Space-Vector Six-Gate Pulse Generator

This block turns one period's worth of space-vector dwell counts into the six gate signals of a three-phase, two-level inverter bridge. It takes the sector number (1 to 6) and three dwell counts: the time spent on the lower-numbered active vector bordering the sector, the time on the higher-numbered one, and the zero-vector time. A free-running triangular carrier is compared against three per-phase thresholds. The thresholds are built from those counts and permuted by sector, which gives the three upper-switch commands.

Each command drives one bridge leg. The lower switch is the complement of the upper one. Every change of a leg opens a programmable dead band in which both switches of that leg are off. Dwell counts and sector are sampled only when the carrier touches zero, so a set written at any other time takes effect at the start of the next period. An asynchronous disable pin forces all six gates off without waiting for a clock edge.

Top module: `svpwm_gate_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, all six gates are low after that edge.
- R2: The carrier counts 0, 1, …, HALF_PERIOD, HALF_PERIOD-1, …, 1 and repeats. Each cycle it moves by one, so every gate pattern repeats every 2·HALF_PERIOD cycles.
- R3: Phase bits are written {a,b,c} with 1 meaning the upper switch is on: V0=000, V1=100, V2=110, V3=010, V4=011, V5=001, V6=101, V7=111. Sector k borders V_k and V_(k+1), and sector 6 borders V6 and V1. `dwell_lo` is the dwell of V_k and `dwell_hi` is the dwell of V_(k+1). In each half carrier, the vector with one bit set is applied first, then the vector with two bits set.
- R4: With h = floor(`dwell_zero`/2), the phase that is on in the first vector has threshold h. The phase added by the second vector has threshold h plus the first vector's dwell. The remaining phase adds the second dwell on top of that. The upper command of a phase is on when carrier ≥ threshold. Over one period, a phase with threshold T (1 ≤ T ≤ HALF_PERIOD) is commanded on for 2·HALF_PERIOD − 2T + 1 cycles; T = 0 means always on. Gate bit 0 is phase a, bit 1 is phase b, bit 2 is phase c.
- R5: The upper and lower gate of one leg are never high in the same cycle.
- R6: After any change of a leg's command, both gates of that leg stay low for `dead_cycles`+1 cycles before the new switch turns on. A command change during that interval restarts it, so a command pulse no longer than the dead band never reaches a gate.
- R7: `dwell_lo`, `dwell_hi`, `dwell_zero` and `sector` are sampled only at the edge where the carrier is at zero. A change at any other time has no effect on the gates until then.
- R8: A sector code of 0 or 7 in the sampling cycle is ignored, and the previously accepted sector stays in force.
- R9: While `force_off` is high, all six gates are low, without waiting for a clock edge. Internal timing continues, so the gates resume the normal pattern when it drops.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| force_off | input | 1 | Asynchronous disable; high forces all gates low |
| dwell_lo | input | CNT_W | Dwell of the lower-numbered bordering vector, in cycles per half period |
| dwell_hi | input | CNT_W | Dwell of the higher-numbered bordering vector |
| dwell_zero | input | CNT_W | Total zero-vector dwell per half period |
| sector | input | 3 | Sector number 1 to 6 |
| dead_cycles | input | DT_W | Dead band length minus one, in cycles |
| gate_hi | output | 3 | Upper-switch gates, bit 0 phase a, bit 2 phase c |
| gate_lo | output | 3 | Lower-switch gates, same bit order |

## Verification
The latch of a new dwell set at the carrier zero and a leg's dead-band start can fall in the same cycle. They collide when the new set gives a phase a zero threshold, so its command rises in the cycle right after sampling. The latch test provokes this by writing such a set mid-slope. It then judges that nothing changed before the zero and that afterwards the leg settles to a full-period upper gate with no lower pulse. The zero-dwell case exercises a second collision: a one-cycle command at the carrier peak lands inside the dead band it has just opened. It is judged by counting that the upper gate never fires and the lower gate loses exactly `dead_cycles`+2 cycles.

// File: rtl/svpwm_pkg.sv
// Shared types and helpers for the space-vector gate generator.
// Assumes phase index 0 = a, 1 = b, 2 = c throughout the design.
package svpwm_pkg;

    typedef logic [1:0] phase_t;

    // Per-sector order of phase turn-on within a rising half carrier.
    typedef struct packed {
        phase_t first;     // on in the one-bit vector
        phase_t second;    // added by the two-bit vector
        phase_t third;     // on only in the all-ones zero vector
        logic   lo_leads;  // 1: the lower-numbered vector is applied first
    } order_t;

    // Map a sector to its switching order from the hexagon encoding.
    function automatic order_t sector_order(input logic [2:0] sec);
        order_t o;
        case (sec)
            3'd1:    o = {2'd0, 2'd1, 2'd2, 1'b1};
            3'd2:    o = {2'd1, 2'd0, 2'd2, 1'b0};
            3'd3:    o = {2'd1, 2'd2, 2'd0, 1'b1};
            3'd4:    o = {2'd2, 2'd1, 2'd0, 1'b0};
            3'd5:    o = {2'd2, 2'd0, 2'd1, 1'b1};
            3'd6:    o = {2'd0, 2'd2, 2'd1, 1'b0};
            default: o = {2'd0, 2'd1, 2'd2, 1'b1};
        endcase
        return o;
    endfunction

    // True for the six legal sector codes.
    function automatic logic sector_ok(input logic [2:0] sec);
        return (sec != 3'd0) && (sec != 3'd7);
    endfunction

endpackage

// File: rtl/svpwm_carrier.sv
// Symmetric up/down carrier counter.
// Counts 0..HALF_PERIOD..1 and repeats; flags the zero cycle.
// Assumes HALF_PERIOD >= 1.
module svpwm_carrier #(
    parameter  int HALF_PERIOD = 64,
    localparam int CNT_W       = $clog2(HALF_PERIOD + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] count,
    output logic             at_zero
);

    localparam logic [CNT_W-1:0] PEAK = CNT_W'(HALF_PERIOD);

    logic rising;

    // Step the triangle one count per cycle, turning at the peak and at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count  <= '0;
            rising <= 1'b1;
        end else if (rising) begin
            if (count >= PEAK) begin
                count  <= count - 1'b1;
                rising <= 1'b0;
            end else begin
                count  <= count + 1'b1;
            end
        end else begin
            if (count == '0) begin
                count  <= count + 1'b1;
                rising <= 1'b1;
            end else begin
                count  <= count - 1'b1;
            end
        end
    end

    // Sampling strobe for the dwell registers.
    assign at_zero = (count == '0);

    // R2
    carrier_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= PEAK);

    // R2
    carrier_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((count == $past(count) + 1'b1) || (count + 1'b1 == $past(count))));

endmodule

// File: rtl/svpwm_threshold.sv
// Samples dwell counts and sector at the carrier zero, builds three
// sector-permuted thresholds and registers the upper-switch commands.
// Assumes dwell_lo + dwell_hi + dwell_zero equals HALF_PERIOD.
module svpwm_threshold
    import svpwm_pkg::*;
#(
    parameter  int HALF_PERIOD = 64,
    localparam int CNT_W       = $clog2(HALF_PERIOD + 1),
    localparam int THR_W       = CNT_W + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count,
    input  logic             at_zero,
    input  logic [CNT_W-1:0] dwell_lo,
    input  logic [CNT_W-1:0] dwell_hi,
    input  logic [CNT_W-1:0] dwell_zero,
    input  logic [2:0]       sector,
    output logic [2:0]       cmd
);

    logic [CNT_W-1:0] lo_q, hi_q, zero_q;
    logic [2:0]       sec_q;
    logic             armed;
    order_t           ord;
    logic [THR_W-1:0] t_first, t_second, t_third;

    // Capture a new dwell set only at the carrier zero; keep the old sector on bad codes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q   <= '0;
            hi_q   <= '0;
            zero_q <= '0;
            sec_q  <= 3'd1;
            armed  <= 1'b0;
        end else if (at_zero) begin
            lo_q   <= dwell_lo;
            hi_q   <= dwell_hi;
            zero_q <= dwell_zero;
            if (sector_ok(sector)) begin
                sec_q <= sector;
            end
            armed  <= 1'b1;
        end
    end

    // Build the three switching instants of a half carrier.
    always_comb begin
        ord      = sector_order(sec_q);
        t_first  = THR_W'(zero_q >> 1);
        t_second = t_first + (ord.lo_leads ? THR_W'(lo_q) : THR_W'(hi_q));
        t_third  = t_second + (ord.lo_leads ? THR_W'(hi_q) : THR_W'(lo_q));
    end

    for (genvar p = 0; p < 3; p++) begin : g_phase
        logic [THR_W-1:0] thr;

        // Pick this phase's instant from the sector order.
        always_comb begin
            if (ord.first == phase_t'(p))
                thr = t_first;
            else if (ord.second == phase_t'(p))
                thr = t_second;
            else
                thr = t_third;
        end

        // Register the carrier comparison as the upper-switch command.
        always_ff @(posedge clk) begin
            if (!rst_n)
                cmd[p] <= 1'b0;
            else
                cmd[p] <= armed && (THR_W'(count) >= thr);
        end
    end

    // R7
    sector_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_q != $past(sec_q)) |-> $past(at_zero));

    // R7
    dwell_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_q != $past(zero_q)) |-> $past(at_zero));

    // R8
    sector_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sector_ok(sec_q));

endmodule

// File: rtl/svpwm_dead_leg.sv
// One bridge leg: complementary gates with a dead band after each command change.
// A change inside a running dead band restarts it; both gates stay low meanwhile.
module svpwm_dead_leg #(
    parameter int DT_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd,
    input  logic [DT_W-1:0] dead_cycles,
    output logic            hi,
    output logic            lo
);

    logic            applied;
    logic [DT_W-1:0] timer;

    // Track the commanded state, run the dead band, then drive one switch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            applied <= 1'b0;
            timer   <= '0;
            hi      <= 1'b0;
            lo      <= 1'b0;
        end else if (cmd != applied) begin
            applied <= cmd;
            timer   <= dead_cycles;
            hi      <= 1'b0;
            lo      <= 1'b0;
        end else if (timer != '0) begin
            timer   <= timer - 1'b1;
            hi      <= 1'b0;
            lo      <= 1'b0;
        end else begin
            hi      <= applied;
            lo      <= ~applied;
        end
    end

    // R5
    no_shoot_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hi && lo));

    // R6
    hi_after_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hi) |-> !$past(lo));

    // R6
    lo_after_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lo) |-> !$past(hi));

endmodule

// File: rtl/svpwm_gate_gen.sv
// Top: carrier, threshold stage and three dead-band legs, plus the
// asynchronous gate disable. Assumes static dead_cycles between changes.
module svpwm_gate_gen #(
    parameter  int HALF_PERIOD = 64,
    parameter  int DT_W        = 8,
    localparam int CNT_W       = $clog2(HALF_PERIOD + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             force_off,
    input  logic [CNT_W-1:0] dwell_lo,
    input  logic [CNT_W-1:0] dwell_hi,
    input  logic [CNT_W-1:0] dwell_zero,
    input  logic [2:0]       sector,
    input  logic [DT_W-1:0]  dead_cycles,
    output logic [2:0]       gate_hi,
    output logic [2:0]       gate_lo
);

    logic [CNT_W-1:0] count;
    logic             at_zero;
    logic [2:0]       cmd;
    logic [2:0]       leg_hi, leg_lo;

    svpwm_carrier #(.HALF_PERIOD(HALF_PERIOD)) u_carrier (
        .clk     (clk),
        .rst_n   (rst_n),
        .count   (count),
        .at_zero (at_zero)
    );

    svpwm_threshold #(.HALF_PERIOD(HALF_PERIOD)) u_threshold (
        .clk        (clk),
        .rst_n      (rst_n),
        .count      (count),
        .at_zero    (at_zero),
        .dwell_lo   (dwell_lo),
        .dwell_hi   (dwell_hi),
        .dwell_zero (dwell_zero),
        .sector     (sector),
        .cmd        (cmd)
    );

    for (genvar p = 0; p < 3; p++) begin : g_leg
        svpwm_dead_leg #(.DT_W(DT_W)) u_leg (
            .clk         (clk),
            .rst_n       (rst_n),
            .cmd         (cmd[p]),
            .dead_cycles (dead_cycles),
            .hi          (leg_hi[p]),
            .lo          (leg_lo[p])
        );
    end

    // Combinational disable path: no clock between force_off and the gates.
    always_comb begin
        gate_hi = leg_hi & {3{~force_off}};
        gate_lo = leg_lo & {3{~force_off}};
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (leg_hi == 3'b000 && leg_lo == 3'b000));

endmodule

// File: tb/svpwm_gate_gen_test.sv
module svpwm_gate_gen_test;

    localparam int P   = 64;
    localparam int W   = $clog2(P + 1);
    localparam int DTW = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           force_off = 1'b0;
    logic [W-1:0]   dlo = '0, dhi = '0, dzero = '0;
    logic [2:0]     sec = 3'd1;
    logic [DTW-1:0] dt = 8'd4;
    logic [2:0]     ghi, glo;

    int errors = 0;
    int checks = 0;
    int overlap = 0;
    int bc = 0;
    bit bup = 1'b1;
    int hi_cnt[3];
    int lo_cnt[3];
    int ethr[3];

    svpwm_gate_gen #(.HALF_PERIOD(P), .DT_W(DTW)) uut (
        .clk(clk), .rst_n(rst_n), .force_off(force_off),
        .dwell_lo(dlo), .dwell_hi(dhi), .dwell_zero(dzero),
        .sector(sec), .dead_cycles(dt),
        .gate_hi(ghi), .gate_lo(glo)
    );

    always #5 clk = ~clk;

    // Bench-side carrier timeline (R2 triangle), value after each edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            bc = 0; bup = 1'b1;
        end else if (bup) begin
            if (bc >= P) begin bc = bc - 1; bup = 1'b0; end
            else bc = bc + 1;
        end else begin
            if (bc == 0) begin bc = 1; bup = 1'b1; end
            else bc = bc - 1;
        end
    end

    // R5 monitor: any leg with both gates high.
    always @(negedge clk) if ((ghi & glo) != 3'b000) overlap++;

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [2:0] vcode(input int n);
        case (n)
            0: return 3'b000; 1: return 3'b100; 2: return 3'b110; 3: return 3'b010;
            4: return 3'b011; 5: return 3'b001; 6: return 3'b101; default: return 3'b111;
        endcase
    endfunction

    // Thresholds from the hexagon encoding (R3, R4).
    task automatic exp_thr(input int s, input int tlo, input int thi, input int tz);
        logic [2:0] vk, vn, one, two;
        int lead, trail, h;
        vk = vcode(s);
        vn = vcode(s == 6 ? 1 : s + 1);
        h = tz / 2;
        if ($countones(vk) == 1) begin one = vk; two = vn; lead = tlo; trail = thi; end
        else begin one = vn; two = vk; lead = thi; trail = tlo; end
        for (int p = 0; p < 3; p++) begin
            if (one[2-p]) ethr[p] = h;
            else if (two[2-p]) ethr[p] = h + lead;
            else ethr[p] = h + lead + trail;
        end
    endtask

    function automatic int n_on(input int thr);
        if (thr == 0) return 2 * P;
        if (thr > P) return 0;
        return 2 * P - 2 * thr + 1;
    endfunction

    function automatic int e_hi(input int n, input int d);
        if (n >= 2 * P) return 2 * P;
        if (n == 0) return 0;
        return n - d - 1;
    endfunction

    function automatic int e_lo(input int n, input int d);
        if (n >= 2 * P) return 0;
        if (n == 0) return 2 * P;
        return 2 * P - n - d - 1;
    endfunction

    // Count gate-high cycles over one full carrier period.
    task automatic measure();
        for (int p = 0; p < 3; p++) begin hi_cnt[p] = 0; lo_cnt[p] = 0; end
        repeat (2 * P) begin
            @(negedge clk);
            for (int p = 0; p < 3; p++) begin
                hi_cnt[p] += int'(ghi[p]);
                lo_cnt[p] += int'(glo[p]);
            end
        end
    endtask

    task automatic apply(input int s, input int tlo, input int thi, input int tz, input int d);
        @(negedge clk);
        sec = 3'(s); dlo = W'(tlo); dhi = W'(thi); dzero = W'(tz); dt = DTW'(d);
        repeat (3 * 2 * P) @(negedge clk);
    endtask

    task automatic check_counts(input string req, input int s, input int tlo,
                                input int thi, input int tz, input int d);
        exp_thr(s, tlo, thi, tz);
        measure();
        for (int p = 0; p < 3; p++) begin
            check(req, $sformatf("sector %0d phase %0d high", s, p), hi_cnt[p], e_hi(n_on(ethr[p]), d));
            check(req, $sformatf("sector %0d phase %0d low", s, p), lo_cnt[p], e_lo(n_on(ethr[p]), d));
        end
    endtask

    task automatic t_reset();
        repeat (4) @(negedge clk);
        check("R1", "upper gates in reset", int'(ghi), 0);
        check("R1", "lower gates in reset", int'(glo), 0);
        rst_n = 1'b1;
    endtask

    task automatic t_sectors();
        for (int s = 1; s <= 6; s++) begin
            apply(s, 20, 12, 32, 4);
            check_counts("R3", s, 20, 12, 32, 4);
        end
    endtask

    task automatic t_split();
        apply(1, 19, 12, 33, 4);
        check_counts("R4", 1, 19, 12, 33, 4);
        // zero dwell = 0: phase a always on, phase c a one-cycle peak pulse
        apply(1, 40, 24, 0, 4);
        measure();
        check("R4", "zero-dwell phase a high", hi_cnt[0], 2 * P);
        check("R4", "zero-dwell phase a low", lo_cnt[0], 0);
        check("R6", "short pulse absorbed high", hi_cnt[2], 0);
        check("R6", "short pulse lower loss", lo_cnt[2], 2 * P - 4 - 2);
    endtask

    task automatic t_dead_and_period();
        int first_rise, second_rise, cyc;
        logic prev;
        apply(1, 20, 12, 32, 0);
        check_counts("R6", 1, 20, 12, 32, 0);
        apply(1, 20, 12, 32, 10);
        check_counts("R6", 1, 20, 12, 32, 10);
        first_rise = -1; second_rise = -1; cyc = 0; prev = ghi[0];
        while (second_rise < 0 && cyc < 8 * P) begin
            @(negedge clk);
            cyc++;
            if (ghi[0] && !prev) begin
                if (first_rise < 0) first_rise = cyc; else second_rise = cyc;
            end
            prev = ghi[0];
        end
        check("R2", "period between upper rises", second_rise - first_rise, 2 * P);
    endtask

    task automatic t_latch();
        apply(1, 0, 0, 64, 4);
        @(negedge clk);
        while (!(bc == 20 && !bup)) @(negedge clk);
        dlo = W'(64); dhi = '0; dzero = '0;
        while (!(bc == 2 && !bup)) @(negedge clk);
        check("R7", "no change before carrier zero", int'(ghi[0]), 0);
        repeat (2 * 2 * P) @(negedge clk);
        measure();
        check("R7", "new set in force high", hi_cnt[0], 2 * P);
        check("R7", "new set in force low", lo_cnt[0], 0);
    endtask

    task automatic t_invalid();
        apply(2, 20, 12, 32, 4);
        apply(7, 20, 12, 32, 4);
        check_counts("R8", 2, 20, 12, 32, 4);
        apply(0, 20, 12, 32, 4);
        check_counts("R8", 2, 20, 12, 32, 4);
    endtask

    task automatic t_force();
        int total;
        apply(1, 20, 12, 32, 4);
        while (!(bc == P)) @(negedge clk);
        check("R9", "phase a on before disable", int'(ghi[0]), 1);
        #1 force_off = 1'b1;
        #1;
        check("R9", "upper gates off at once", int'(ghi), 0);
        check("R9", "lower gates off at once", int'(glo), 0);
        measure();
        total = 0;
        for (int p = 0; p < 3; p++) total += hi_cnt[p] + lo_cnt[p];
        check("R9", "gate cycles while disabled", total, 0);
        @(negedge clk);
        force_off = 1'b0;
        check_counts("R9", 1, 20, 12, 32, 4);
    endtask

    initial begin
        t_reset();
        t_sectors();
        t_split();
        t_dead_and_period();
        t_latch();
        t_invalid();
        t_force();
        check("R5", "cycles with both gates of a leg high", overlap, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 10);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule